// File: doc/BRIEF.md
# Direct-Mapped Write-Through Data Cache

This block is a data cache that sits between a processor load/store port and a memory port one word wide. It has 64 lines of 16 bytes. A load that finds its line answers in the same cycle. A load that misses holds the processor and fetches the whole four-word line from memory. It then records the line's tag and marks the line valid, and the held load is presented again so that it hits. Every store is written to memory. Stores are queued in a four-entry write buffer so the processor does not wait for memory. A store also updates the cache when its line is present. A store that misses does not bring the line in.

The processor holds its request, address, data and byte enables steady while `cpu_stall` is high. An access completes on the first rising edge at which the request is high and the stall is low. The memory side has two channels. The read channel takes a one-cycle line request and returns four words in order, each marked by `mem_rvalid`. The write channel offers the oldest queued store and holds it until memory accepts it with `mem_wr_ready`.

Top module: `wt_dcache`

## Requirements
- R1: A byte address is split into tag = bits [31:10], line index = bits [9:4] and byte offset = bits [3:0]. The line used is (address / 16) mod 64, so byte address 1200 uses line 11. Two addresses with the same index and different tags evict each other. Different indices do not disturb each other.
- R2: A load whose line is valid with a matching tag completes in the cycle it is presented, with `cpu_stall` low. It returns the word chosen by address bits [3:2].
- R3: After reset the cache spends 64 cycles marking every line invalid, holding `cpu_stall` high the whole time. The first load to any address after this sweep misses.
- R4: A load miss starts its refill only once the write buffer is empty. The refill starts with `mem_rd` high for exactly one cycle, carrying the line-aligned address (bits [3:0] zero), and `mem_rd` is never high in the same cycle as `mem_wr`.
- R5: The refill takes four words in order, word 0 first. After the fourth word the line is marked valid with the tag of the missed address, and the held load then hits. Memory takes 1 address cycle plus 15 access cycles and 1 transfer cycle per word, which is 65 cycles. With an empty write buffer, a load miss therefore keeps `cpu_stall` high for 66 cycles.
- R6: A store that hits changes only the bytes of the cached word whose `cpu_be` bit is set; bit i covers data bits [8i+7:8i].
- R7: Every store, hit or miss, is sent to memory with its address, data and byte enables. Stores reach memory in program order. A store miss does not allocate a line.
- R8: The write buffer holds 4 stores. A store stalls only while the buffer is full.
- R9: While `mem_wr` is high and `mem_wr_ready` is low, `mem_wr` stays high and its address, data and byte enables stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_req | input | 1 | Processor access request |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 32 | Byte address |
| cpu_be | input | 4 | Store byte enables |
| cpu_wdata | input | 32 | Store data |
| cpu_rdata | output | 32 | Load data, valid when a load completes |
| cpu_stall | output | 1 | Processor must hold its request |
| mem_rd | output | 1 | One-cycle line read request |
| mem_rd_addr | output | 32 | Line-aligned read address |
| mem_rvalid | input | 1 | Refill word present on mem_rdata |
| mem_rdata | input | 32 | Refill word |
| mem_wr | output | 1 | Queued store offered to memory |
| mem_wr_addr | output | 32 | Store byte address |
| mem_wr_data | output | 32 | Store data |
| mem_wr_be | output | 4 | Store byte enables |
| mem_wr_ready | input | 1 | Memory accepts the offered store |

## Verification
The assertions check five things on every cycle:
- the stall is held during the invalidation sweep;
- a load can only complete on a hit;
- a line read starts only with an empty buffer, is one cycle long, is aligned, and never overlaps a write;
- the buffer never holds more than four stores, and a store with space is not stalled;
- a refused write keeps its payload steady.

Other behaviour can only be shown by the bench's scenarios. Tag/index aliasing, the exact 66-cycle miss time, and byte merging inside a cached word are among them. So are program-order arrival of stores at memory, the absence of allocation on a store miss, and a load that returns data still sitting in the buffer after waiting for it to drain.

// File: rtl/dc_pkg.sv
// Shared constants and types of the write-through data cache.
// Assumes 32-bit byte addresses and 32-bit words.
package dc_pkg;
    localparam int ADDR_W = 32;
    localparam int DATA_W = 32;
    localparam int BE_W   = DATA_W / 8;

    // Controller states: invalidation sweep, ready, line request, line fill
    typedef enum logic [1:0] {
        ST_INIT = 2'd0,
        ST_IDLE = 2'd1,
        ST_REQ  = 2'd2,
        ST_FILL = 2'd3
    } dc_state_e;

    // One queued store
    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic [BE_W-1:0]   be;
    } wb_entry_t;
endpackage

// File: rtl/dc_tag_store.sv
// Valid bits and tags, one per line.
// Lookup is combinational on the presented index and tag.
// The valid bits have no reset: the controller clears them one line per cycle
// after reset, and nothing trusts a lookup until that sweep is over.
module dc_tag_store #(
    parameter int IDX_W = 6,
    parameter int TAG_W = 22
) (
    input  logic             clk,
    input  logic [IDX_W-1:0] lk_idx,
    input  logic [TAG_W-1:0] lk_tag,
    input  logic             clr_en,
    input  logic [IDX_W-1:0] clr_idx,
    input  logic             set_en,
    input  logic [IDX_W-1:0] set_idx,
    input  logic [TAG_W-1:0] set_tag,
    output logic             hit
);
    localparam int LINES = 1 << IDX_W;

    logic [LINES-1:0] valid_q;
    logic [TAG_W-1:0] tag_q [LINES];

    // Valid bits: the sweep clears them, a completed refill sets one
    always_ff @(posedge clk) begin
        if (clr_en) begin
            valid_q[clr_idx] <= 1'b0;
        end else if (set_en) begin
            valid_q[set_idx] <= 1'b1;
        end
    end

    // Tag field written when a refill completes
    always_ff @(posedge clk) begin
        if (set_en) begin
            tag_q[set_idx] <= set_tag;
        end
    end

    // Hit: the line is valid and its stored tag matches
    always_comb begin
        hit = valid_q[lk_idx] && (tag_q[lk_idx] == lk_tag);
    end
endmodule

// File: rtl/dc_data_store.sv
// Line data held as words, addressed by {line index, word select}.
// Read is combinational. A write merges the enabled bytes into the old word;
// a refill word is written with all byte enables set.
module dc_data_store #(
    parameter int IDX_W  = 6,
    parameter int WSEL_W = 2,
    parameter int DATA_W = 32
) (
    input  logic                      clk,
    input  logic [IDX_W+WSEL_W-1:0]   rd_ptr,
    output logic [DATA_W-1:0]         rd_data,
    input  logic                      wr_en,
    input  logic [IDX_W+WSEL_W-1:0]   wr_ptr,
    input  logic [DATA_W-1:0]         wr_data,
    input  logic [DATA_W/8-1:0]       wr_be
);
    localparam int PTR_W  = IDX_W + WSEL_W;
    localparam int NWORDS = 1 << PTR_W;
    localparam int NBYTES = DATA_W / 8;

    logic [DATA_W-1:0] words_q [NWORDS];
    logic [DATA_W-1:0] old_word;
    logic [DATA_W-1:0] merged;

    // Old contents of the word being written
    always_comb begin
        old_word = words_q[wr_ptr];
    end

    // Merge each enabled byte lane over the old word
    for (genvar b = 0; b < NBYTES; b++) begin : g_lane
        assign merged[8*b +: 8] = wr_be[b] ? wr_data[8*b +: 8] : old_word[8*b +: 8];
    end

    // Word array update
    always_ff @(posedge clk) begin
        if (wr_en) begin
            words_q[wr_ptr] <= merged;
        end
    end

    // Combinational read port for the hit path
    always_comb begin
        rd_data = words_q[rd_ptr];
    end
endmodule

// File: rtl/dc_wbuf.sv
// Write buffer: a FIFO of stores waiting for the memory write channel.
// Assumes DEPTH is a power of two of at least 2. Push and pop may happen in
// the same cycle. The user never pushes when full or pops when empty.
module dc_wbuf
    import dc_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  wb_entry_t        push_ent,
    input  logic             pop,
    output wb_entry_t        head,
    output logic             empty,
    output logic             full,
    output logic [CNT_W-1:0] count
);
    localparam int PTR_W = $clog2(DEPTH);

    wb_entry_t        slot_q [DEPTH];
    logic [PTR_W-1:0] wr_ptr_q;
    logic [PTR_W-1:0] rd_ptr_q;
    logic [CNT_W-1:0] cnt_q;

    // Pointers and occupancy
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            cnt_q    <= '0;
        end else begin
            if (push) wr_ptr_q <= wr_ptr_q + 1'b1;
            if (pop)  rd_ptr_q <= rd_ptr_q + 1'b1;
            cnt_q <= cnt_q + CNT_W'(push) - CNT_W'(pop);
        end
    end

    // Entry storage
    always_ff @(posedge clk) begin
        if (push) begin
            slot_q[wr_ptr_q] <= push_ent;
        end
    end

    // Oldest entry and occupancy flags
    always_comb begin
        head  = slot_q[rd_ptr_q];
        empty = (cnt_q == '0);
        full  = (cnt_q == CNT_W'(DEPTH));
        count = cnt_q;
    end
endmodule

// File: rtl/dc_ctrl.sv
// Cache controller.
// - Runs the invalidation sweep after reset.
// - Decides when the processor must wait.
// - Sequences a line refill: wait for the write buffer to drain, issue one
//   line request, then count the returned words.
// Assumes the processor holds its request steady while stalled.
module dc_ctrl
    import dc_pkg::*;
#(
    parameter int IDX_W  = 6,
    parameter int WSEL_W = 2,
    parameter int LINE_W = 28
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              we,
    input  logic              hit,
    input  logic              wb_empty,
    input  logic              wb_full,
    input  logic [LINE_W-1:0] line_in,
    input  logic              mem_rvalid,
    output logic              stall,
    output dc_state_e         state,
    output logic              clr_en,
    output logic [IDX_W-1:0]  clr_idx,
    output logic              mem_rd,
    output logic [LINE_W-1:0] miss_line,
    output logic              fill_en,
    output logic [WSEL_W-1:0] fill_word,
    output logic              fill_done
);
    dc_state_e         st_q;
    logic [IDX_W-1:0]  sweep_q;
    logic [WSEL_W-1:0] word_q;
    logic [LINE_W-1:0] line_q;
    logic              rd_miss;

    // Load that needs a refill
    always_comb begin
        rd_miss = req && !we && !hit;
    end

    // State register and transitions
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ST_INIT;
        end else begin
            unique case (st_q)
                ST_INIT: if (sweep_q == '1) st_q <= ST_IDLE;
                ST_IDLE: if (rd_miss && wb_empty) st_q <= ST_REQ;
                ST_REQ:  st_q <= ST_FILL;
                ST_FILL: if (mem_rvalid && word_q == '1) st_q <= ST_IDLE;
                default: st_q <= ST_INIT;
            endcase
        end
    end

    // Sweep counter: one line per cycle during ST_INIT
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sweep_q <= '0;
        end else if (st_q == ST_INIT) begin
            sweep_q <= sweep_q + 1'b1;
        end
    end

    // Refill word counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
        end else if (st_q == ST_REQ) begin
            word_q <= '0;
        end else if (st_q == ST_FILL && mem_rvalid) begin
            word_q <= word_q + 1'b1;
        end
    end

    // Line address of the miss, captured when the refill starts
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_q <= '0;
        end else if (st_q == ST_IDLE && rd_miss && wb_empty) begin
            line_q <= line_in;
        end
    end

    // Outputs derived from the state
    always_comb begin
        stall     = (st_q != ST_IDLE) || rd_miss || (req && we && wb_full);
        state     = st_q;
        clr_en    = (st_q == ST_INIT);
        clr_idx   = sweep_q;
        mem_rd    = (st_q == ST_REQ);
        miss_line = line_q;
        fill_en   = (st_q == ST_FILL) && mem_rvalid;
        fill_word = word_q;
        fill_done = fill_en && (word_q == '1);
    end
endmodule

// File: rtl/wt_dcache.sv
// Direct-mapped write-through data cache, top level.
// - Splits the address into tag / index / offset.
// - Answers load hits combinationally and refills whole lines on load misses.
// - Writes hitting stores into the line.
// - Queues every store for memory; store misses do not allocate.
// Assumes the processor holds cpu_* steady while cpu_stall is high.
module wt_dcache
    import dc_pkg::*;
#(
    parameter int IDX_W    = 6,
    parameter int OFF_W    = 4,
    parameter int WB_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [BE_W-1:0]   cpu_be,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_stall,
    output logic              mem_rd,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic              mem_rvalid,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              mem_wr,
    output logic [ADDR_W-1:0] mem_wr_addr,
    output logic [DATA_W-1:0] mem_wr_data,
    output logic [BE_W-1:0]   mem_wr_be,
    input  logic              mem_wr_ready
);
    localparam int TAG_W    = ADDR_W - IDX_W - OFF_W;
    localparam int WSEL_W   = OFF_W - 2;
    localparam int LINE_W   = ADDR_W - OFF_W;
    localparam int PTR_W    = IDX_W + WSEL_W;
    localparam int WB_CNT_W = $clog2(WB_DEPTH + 1);

    logic [IDX_W-1:0]    cur_idx;
    logic [TAG_W-1:0]    cur_tag;
    logic [WSEL_W-1:0]   cur_word;
    logic [LINE_W-1:0]   cur_line;
    logic                lk_hit;
    logic                wb_empty;
    logic                wb_full;
    logic [WB_CNT_W-1:0] wb_cnt;
    wb_entry_t           wb_head;
    wb_entry_t           wb_in;
    logic                wb_pop;
    logic                store_go;
    logic                store_hit;
    dc_state_e           ctl_state;
    logic                clr_en;
    logic [IDX_W-1:0]    clr_idx;
    logic [LINE_W-1:0]   miss_line;
    logic                fill_en;
    logic [WSEL_W-1:0]   fill_word;
    logic                fill_done;
    logic                dwr_en;
    logic [PTR_W-1:0]    dwr_ptr;
    logic [DATA_W-1:0]   dwr_data;
    logic [BE_W-1:0]     dwr_be;

    // Address fields of the presented access
    always_comb begin
        cur_idx  = cpu_addr[OFF_W +: IDX_W];
        cur_tag  = cpu_addr[ADDR_W-1 -: TAG_W];
        cur_word = cpu_addr[2 +: WSEL_W];
        cur_line = cpu_addr[ADDR_W-1:OFF_W];
    end

    dc_tag_store #(
        .IDX_W (IDX_W),
        .TAG_W (TAG_W)
    ) i_tags (
        .clk     (clk),
        .lk_idx  (cur_idx),
        .lk_tag  (cur_tag),
        .clr_en  (clr_en),
        .clr_idx (clr_idx),
        .set_en  (fill_done),
        .set_idx (miss_line[IDX_W-1:0]),
        .set_tag (miss_line[LINE_W-1 -: TAG_W]),
        .hit     (lk_hit)
    );

    dc_ctrl #(
        .IDX_W  (IDX_W),
        .WSEL_W (WSEL_W),
        .LINE_W (LINE_W)
    ) i_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .req        (cpu_req),
        .we         (cpu_we),
        .hit        (lk_hit),
        .wb_empty   (wb_empty),
        .wb_full    (wb_full),
        .line_in    (cur_line),
        .mem_rvalid (mem_rvalid),
        .stall      (cpu_stall),
        .state      (ctl_state),
        .clr_en     (clr_en),
        .clr_idx    (clr_idx),
        .mem_rd     (mem_rd),
        .miss_line  (miss_line),
        .fill_en    (fill_en),
        .fill_word  (fill_word),
        .fill_done  (fill_done)
    );

    // Store that completes this cycle, and whether its line is present
    always_comb begin
        store_go  = cpu_req && cpu_we && !cpu_stall;
        store_hit = store_go && lk_hit;
    end

    // Data array write source: a refill word has priority (stores stall during a refill)
    always_comb begin
        if (fill_en) begin
            dwr_en   = 1'b1;
            dwr_ptr  = {miss_line[IDX_W-1:0], fill_word};
            dwr_data = mem_rdata;
            dwr_be   = '1;
        end else begin
            dwr_en   = store_hit;
            dwr_ptr  = {cur_idx, cur_word};
            dwr_data = cpu_wdata;
            dwr_be   = cpu_be;
        end
    end

    dc_data_store #(
        .IDX_W  (IDX_W),
        .WSEL_W (WSEL_W),
        .DATA_W (DATA_W)
    ) i_data (
        .clk     (clk),
        .rd_ptr  ({cur_idx, cur_word}),
        .rd_data (cpu_rdata),
        .wr_en   (dwr_en),
        .wr_ptr  (dwr_ptr),
        .wr_data (dwr_data),
        .wr_be   (dwr_be)
    );

    // Store record entering the write buffer
    always_comb begin
        wb_in.addr = cpu_addr;
        wb_in.data = cpu_wdata;
        wb_in.be   = cpu_be;
    end

    dc_wbuf #(
        .DEPTH (WB_DEPTH),
        .CNT_W (WB_CNT_W)
    ) i_wbuf (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (store_go),
        .push_ent (wb_in),
        .pop      (wb_pop),
        .head     (wb_head),
        .empty    (wb_empty),
        .full     (wb_full),
        .count    (wb_cnt)
    );

    // Memory write channel driven from the buffer head
    always_comb begin
        mem_wr      = !wb_empty;
        mem_wr_addr = wb_head.addr;
        mem_wr_data = wb_head.data;
        mem_wr_be   = wb_head.be;
        wb_pop      = mem_wr && mem_wr_ready;
    end

    // Memory read channel: line-aligned request address
    always_comb begin
        mem_rd_addr = {miss_line, {OFF_W{1'b0}}};
    end
endmodule

// File: rtl/dc_chk.sv
// Cycle-level properties of the cache, attached to wt_dcache by bind.
module dc_chk
    import dc_pkg::*;
#(
    parameter int OFF_W    = 4,
    parameter int WB_DEPTH = 4,
    parameter int CNT_W    = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_req,
    input logic              cpu_we,
    input logic              cpu_stall,
    input logic              hit,
    input logic              mem_rd,
    input logic [ADDR_W-1:0] mem_rd_addr,
    input logic              mem_rvalid,
    input logic              mem_wr,
    input logic              mem_wr_ready,
    input logic [ADDR_W-1:0] mem_wr_addr,
    input logic [DATA_W-1:0] mem_wr_data,
    input logic [BE_W-1:0]   mem_wr_be,
    input logic              wb_full,
    input logic [CNT_W-1:0]  wb_cnt,
    input dc_state_e         st
);
    // R3
    sweep_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_INIT) |-> (cpu_stall && !mem_rd));

    // R2
    load_done_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && !cpu_we && !cpu_stall) |-> hit);

    // R4
    rd_after_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |-> (wb_cnt == '0 && mem_rd_addr[OFF_W-1:0] == '0 && !mem_wr));

    // R4
    rd_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> !mem_rd);

    // R5
    fill_stalls_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rvalid |-> cpu_stall);

    // R8
    wb_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_cnt <= CNT_W'(WB_DEPTH));

    // R8
    store_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && cpu_we && !wb_full && st == ST_IDLE) |-> !cpu_stall);

    // R9
    wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr && !mem_wr_ready) |=> (mem_wr && $stable(mem_wr_addr)
            && $stable(mem_wr_data) && $stable(mem_wr_be)));
endmodule

bind wt_dcache dc_chk #(
    .OFF_W    (OFF_W),
    .WB_DEPTH (WB_DEPTH),
    .CNT_W    (WB_CNT_W)
) i_dc_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cpu_req      (cpu_req),
    .cpu_we       (cpu_we),
    .cpu_stall    (cpu_stall),
    .hit          (lk_hit),
    .mem_rd       (mem_rd),
    .mem_rd_addr  (mem_rd_addr),
    .mem_rvalid   (mem_rvalid),
    .mem_wr       (mem_wr),
    .mem_wr_ready (mem_wr_ready),
    .mem_wr_addr  (mem_wr_addr),
    .mem_wr_data  (mem_wr_data),
    .mem_wr_be    (mem_wr_be),
    .wb_full      (wb_full),
    .wb_cnt       (wb_cnt),
    .st           (ctl_state)
);

// File: tb/test_wt_dcache.sv
module test_wt_dcache;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req = 1'b0;
    logic        cpu_we = 1'b0;
    logic [31:0] cpu_addr = '0;
    logic [3:0]  cpu_be = '0;
    logic [31:0] cpu_wdata = '0;
    logic [31:0] cpu_rdata;
    logic        cpu_stall;
    logic        mem_rd;
    logic [31:0] mem_rd_addr;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        mem_wr;
    logic [31:0] mem_wr_addr;
    logic [31:0] mem_wr_data;
    logic [3:0]  mem_wr_be;
    logic        mem_wr_ready = 1'b0;

    int n_vec = 0;
    int n_bad = 0;

    always #4 clk = ~clk;  // 125 MHz

    wt_dcache i_wt_dcache (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_be(cpu_be), .cpu_wdata(cpu_wdata),
        .cpu_rdata(cpu_rdata), .cpu_stall(cpu_stall), .mem_rd(mem_rd),
        .mem_rd_addr(mem_rd_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .mem_wr(mem_wr), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
        .mem_wr_be(mem_wr_be), .mem_wr_ready(mem_wr_ready)
    );

    // Memory model (word array) and the program-order view of memory
    logic [31:0] mem_model [1024];
    logic [31:0] shadow    [1024];
    logic        wr_hold = 1'b0;
    bit          rd_busy = 1'b0;
    int          rd_cnt = 0;
    int          rd_pulses = 0;
    logic [31:0] rd_base = '0;
    logic [31:0] last_rd = '0;

    function automatic logic [31:0] merge(logic [31:0] o, logic [31:0] d, logic [3:0] be);
        logic [31:0] r;
        for (int b = 0; b < 4; b++) r[8*b +: 8] = be[b] ? d[8*b +: 8] : o[8*b +: 8];
        return r;
    endfunction

    initial begin
        for (int i = 0; i < 1024; i++) begin
            mem_model[i] = {16'hC0DE, 6'd0, i[9:0]};
            shadow[i]    = {16'hC0DE, 6'd0, i[9:0]};
        end
    end

    // Memory timing: address cycle, then per word 15 access + 1 transfer cycle
    always @(negedge clk) begin
        mem_rvalid = 1'b0;
        if (!rst_n) begin
            rd_busy = 1'b0;
        end else if (rd_busy) begin
            rd_cnt++;
            if (rd_cnt % 16 == 1) begin
                mem_rvalid = 1'b1;
                mem_rdata  = mem_model[rd_base[11:2] + 10'((rd_cnt - 17) / 16)];
                if (rd_cnt == 65) rd_busy = 1'b0;
            end
        end else if (mem_rd) begin
            rd_busy   = 1'b1;
            rd_cnt    = 1;
            rd_base   = mem_rd_addr;
            last_rd   = mem_rd_addr;
            rd_pulses++;
        end
        mem_wr_ready = !wr_hold && !rd_busy;
        if (rst_n && mem_wr && mem_wr_ready)
            mem_model[mem_wr_addr[11:2]] = merge(mem_model[mem_wr_addr[11:2]], mem_wr_data, mem_wr_be);
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Present one access, wait for it to complete, record stall behaviour
    task automatic do_op(input logic we, input logic [31:0] a, input logic [31:0] d,
                         input logic [3:0] be, output logic stalled, output int nst,
                         output logic [31:0] rd);
        @(negedge clk); #1;
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d; cpu_be = be;
        #1;
        stalled = cpu_stall;
        nst = 0;
        while (cpu_stall) begin
            @(negedge clk); #2;
            nst++;
        end
        rd = cpu_rdata;
        @(posedge clk); #1;
        cpu_req = 1'b0; cpu_we = 1'b0;
        if (we) shadow[a[11:2]] = merge(shadow[a[11:2]], d, be);
    endtask

    typedef struct packed {
        logic        we;
        logic [31:0] addr;
        logic [31:0] wdata;
        logic [3:0]  be;
        logic        miss;
    } vec_t;

    // Op list: line 11 (byte address 1200) and its aliases, then line 2 and 12
    localparam vec_t VECS [15] = '{
        '{1'b0, 32'h0000_04B0, 32'h0,          4'h0, 1'b1},  // R3 cold miss after sweep
        '{1'b0, 32'h0000_04B4, 32'h0,          4'h0, 1'b0},  // R2 word 1 of same line
        '{1'b0, 32'h0000_04BC, 32'h0,          4'h0, 1'b0},  // R2 word 3
        '{1'b1, 32'h0000_04B4, 32'h1122_3344,  4'hF, 1'b0},  // R6 store hit
        '{1'b0, 32'h0000_04B4, 32'h0,          4'h0, 1'b0},
        '{1'b1, 32'h0000_04B8, 32'hAAAA_5555,  4'h3, 1'b0},  // R6 low two bytes only
        '{1'b0, 32'h0000_04B8, 32'h0,          4'h0, 1'b0},
        '{1'b0, 32'h0000_08B0, 32'h0,          4'h0, 1'b1},  // R1 same index, other tag
        '{1'b0, 32'h0000_04B0, 32'h0,          4'h0, 1'b1},  // R1 evicted
        '{1'b0, 32'h0000_04B4, 32'h0,          4'h0, 1'b0},  // R7 store reached memory
        '{1'b1, 32'h0000_0020, 32'h5A5A_0F0F,  4'hF, 1'b0},  // R7 store miss
        '{1'b0, 32'h0000_0020, 32'h0,          4'h0, 1'b1},  // R7 no allocate
        '{1'b0, 32'h0000_002C, 32'h0,          4'h0, 1'b0},
        '{1'b0, 32'h0000_04C0, 32'h0,          4'h0, 1'b1},  // R1 line 12
        '{1'b0, 32'h0000_04B4, 32'h0,          4'h0, 1'b0}   // R1 line 11 kept
    };

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL R5: watchdog expired, actual %0d cycles expected fewer", 150000);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        logic        st;
        int          ns;
        logic [31:0] rd;
        int          sweep;
        int          pulses0;
        bit          early_rd;

        // Reset and invalidation sweep (R3)
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #2;
        sweep = 0;
        while (cpu_stall) begin
            sweep++;
            @(negedge clk); #2;
        end
        check(sweep == 64, "R3 sweep length", sweep, 64);
        check(!mem_wr && !mem_rd, "R3 idle memory ports", {mem_wr, mem_rd}, 0);

        // Table walk
        for (int i = 0; i < 15; i++) begin
            do_op(VECS[i].we, VECS[i].addr, VECS[i].wdata, VECS[i].be, st, ns, rd);
            check(st == VECS[i].miss, VECS[i].we ? "R8 store stall" : (VECS[i].miss ? "R5 miss" : "R2 hit"),
                  st, VECS[i].miss);
            if (!VECS[i].we)
                check(rd == shadow[VECS[i].addr[11:2]], VECS[i].miss ? "R5 refill data" : "R2 hit data",
                      rd, shadow[VECS[i].addr[11:2]]);
            if (i == 0) begin
                check(ns == 66, "R5 miss stall cycles", ns, 66);
                check(last_rd == 32'h4B0, "R4 line address", last_rd, 32'h4B0);
            end
        end

        // Byte merge seen through a hit (R6)
        do_op(1'b0, 32'h4B8, 0, 0, st, ns, rd);
        check(rd == 32'hC0DE_5555, "R6 merged word", rd, 32'hC0DE_5555);
        // 0x8B4 evicted by 0x4B0 (R1)
        do_op(1'b0, 32'h8B4, 0, 0, st, ns, rd);
        check(st == 1'b1, "R1 alias evicted", st, 1);
        check(last_rd == 32'h8B0, "R4 aligned request", last_rd, 32'h8B0);

        // Buffer fill with memory refusing writes (R8, R9, R7 ordering)
        @(negedge clk); #1 wr_hold = 1'b1;
        do_op(1'b1, 32'h200, 32'h0000_00A1, 4'hF, st, ns, rd);
        check(!st, "R8 store 1 no stall", st, 0);
        do_op(1'b1, 32'h204, 32'h0000_00B2, 4'hF, st, ns, rd);
        check(!st, "R8 store 2 no stall", st, 0);
        do_op(1'b1, 32'h200, 32'h0000_00C3, 4'hF, st, ns, rd);
        check(!st, "R8 store 3 no stall", st, 0);
        do_op(1'b1, 32'h208, 32'h0000_00D4, 4'hF, st, ns, rd);
        check(!st, "R8 store 4 no stall", st, 0);
        @(negedge clk); #1;
        cpu_req = 1'b1; cpu_we = 1'b1; cpu_addr = 32'h20C; cpu_wdata = 32'hE5; cpu_be = 4'hF;
        #1;
        check(cpu_stall, "R8 fifth store stalls", cpu_stall, 1);
        check(mem_wr_addr == 32'h200 && mem_wr_data == 32'hA1, "R9 head held", mem_wr_data, 32'hA1);
        repeat (5) @(negedge clk);
        #2;
        check(cpu_stall, "R8 still full", cpu_stall, 1);
        check(mem_wr_addr == 32'h200 && mem_wr_data == 32'hA1, "R9 head stable", mem_wr_data, 32'hA1);
        wr_hold = 1'b0;
        while (cpu_stall) begin @(negedge clk); #2; end
        @(posedge clk); #1 cpu_req = 1'b0; cpu_we = 1'b0;
        shadow[32'h20C >> 2] = 32'hE5;
        repeat (10) @(negedge clk);
        check(mem_model[32'h200 >> 2] == 32'hC3, "R7 order same address", mem_model[32'h200 >> 2], 32'hC3);
        check(mem_model[32'h204 >> 2] == 32'hB2, "R7 store 2 in memory", mem_model[32'h204 >> 2], 32'hB2);
        check(mem_model[32'h20C >> 2] == 32'hE5, "R7 store 5 in memory", mem_model[32'h20C >> 2], 32'hE5);
        check(mem_model[32'h4B4 >> 2] == 32'h1122_3344, "R7 write-through hit", mem_model[32'h4B4 >> 2], 32'h1122_3344);
        check(mem_model[32'h4B8 >> 2] == 32'hC0DE_5555, "R6 bytes in memory", mem_model[32'h4B8 >> 2], 32'hC0DE_5555);

        // Load miss waits for the buffer to drain (R4)
        @(negedge clk); #1 wr_hold = 1'b1;
        do_op(1'b1, 32'h304, 32'h7777_1234, 4'hF, st, ns, rd);
        pulses0 = rd_pulses;
        @(negedge clk); #1;
        cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = 32'h304;
        early_rd = 1'b0;
        for (int k = 0; k < 10; k++) begin
            @(negedge clk); #2;
            if (rd_pulses != pulses0 || mem_rd) early_rd = 1'b1;
        end
        check(!early_rd, "R4 no read before drain", early_rd, 0);
        check(cpu_stall, "R4 load held", cpu_stall, 1);
        wr_hold = 1'b0;
        while (cpu_stall) begin @(negedge clk); #2; end
        rd = cpu_rdata;
        @(posedge clk); #1 cpu_req = 1'b0;
        check(rd == 32'h7777_1234, "R4 load sees drained store", rd, 32'h7777_1234);
        check(rd_pulses == pulses0 + 1, "R4 single line request", rd_pulses, pulses0 + 1);
        check(last_rd == 32'h300, "R4 request aligned", last_rd, 32'h300);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule